// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular store of 256-byte pages in a local RAM. The host programs the first and one-past-last pages of the ring and a boundary page, which marks where its own unread data sits. Frames arrive as a byte stream with valid, data and last strobes. Good/bad flags and error flags come with the last byte. The block writes the payload into RAM starting four bytes into the current page, and the next byte always goes to the following address. Once the last page of the ring is full, writing carries on at the first page.

When a frame ends, the block goes back to the frame's first page and fills the four reserved bytes with a header: a status byte, the page where the next frame will start, and the stored length, low byte first. The current-page register then moves to that next page and a one-cycle completion pulse is raised. A frame may need to move into the boundary page, or may end such that the next frame would start there. In that case the frame is abandoned: no more bytes are written, no header is written, the current page stays where it was, and a one-cycle overwrite warning is raised.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the current page reads as the reset start page (0x46 by default), and neither the RAM write strobe nor the overwrite warning is asserted.
- R2: A configuration write with page select 0 sets the ring start page at offset 1, the stop page at offset 2 and the boundary page at offset 3. With page select 1, offset 7 sets the current page. A write with page select 0 to offset 7 leaves the current page unchanged.
- R3: The first payload byte is written at byte offset 4 of the current page (RAM address = page*256 + offset). Every later payload byte goes to the next higher address.
- R4: When a payload byte fills the last byte of page stop-1, the next byte is written at offset 0 of the start page.
- R5: After the last byte, four header bytes are written at offsets 0,1,2,3 of the frame's first page, in this order: status, next page, length low, length high. The length is the payload byte count plus 4.
- R6: In the status byte, bit 0 is the good flag, bit 1 the CRC error, bit 2 the alignment error and bit 3 the FIFO overrun. Bits 7:4 are zero.
- R7: The next page is the page that follows the one holding the last written byte, wrapping at the stop page. If the frame ends exactly at a page end, it is the page that comes next. The current page takes this value when the header is complete, and frame_done pulses for one cycle at that moment.
- R8: If a payload byte would go into the boundary page, the frame is abandoned. That byte and all later bytes of the frame are not written, no header is written, the current page is not changed, and ovw_irq pulses once.
- R9: If a frame ends with its next page equal to the boundary page, all of its payload stays written but no header is written, the current page is not changed, and ovw_irq pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_page | input | 1 | Register page select |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_good | input | 1 | Frame intact, sampled with last |
| rx_crc_err | input | 1 | CRC error flag, sampled with last |
| rx_align_err | input | 1 | Alignment error flag, sampled with last |
| rx_fifo_err | input | 1 | FIFO overrun flag, sampled with last |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cur_page | output | 8 | Current-page register |
| frame_done | output | 1 | Pulse when a frame has been committed |
| ovw_irq | output | 1 | Pulse when a frame is abandoned on overwrite |

## Verification
The assertions rely on three conditions about the inputs. No byte is offered during the four header-write cycles that follow a frame's last byte. The ring registers change only while no frame is in progress. The start page is below the stop page, and the current and boundary pages lie inside the ring. The stimulus leaves at least eight idle cycles after each last byte, and it makes every configuration write between frames with consistent page values. A scoreboard predicts every RAM write, in order, from the requirements. It also predicts the current page and the warning and completion pulses for each frame.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
package rx_ring_pkg;
  parameter int PG_W      = 8;
  parameter int OFF_W     = 8;
  parameter int ADDR_W    = PG_W + OFF_W;
  parameter int LEN_W     = 16;
  parameter int HDR_BYTES = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR} wr_state_e;

  // page that follows pg inside the ring [start, stop)
  function automatic logic [PG_W-1:0] ring_step(input logic [PG_W-1:0] pg,
                                                input logic [PG_W-1:0] start,
                                                input logic [PG_W-1:0] stop);
    logic [PG_W-1:0] n;
    n = pg + 1'b1;
    return (n == stop) ? start : n;
  endfunction

  function automatic logic [7:0] pack_status(input logic good, input logic crc,
                                             input logic align, input logic fifo);
    return {4'b0000, fifo, align, crc, good};
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic [7:0] status,
                                          input logic [PG_W-1:0] nxt,
                                          input logic [LEN_W-1:0] len);
    case (idx)
      2'd0:    return status;
      2'd1:    return nxt;
      2'd2:    return len[7:0];
      default: return len[15:8];
    endcase
  endfunction
endpackage

// File: rtl/rx_ring_cfg.sv
`timescale 1ns/1ps
module rx_ring_cfg
  import rx_ring_pkg::*;
#(
  parameter logic [PG_W-1:0] RST_START = 8'h46,
  parameter logic [PG_W-1:0] RST_STOP  = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_page,
  input  logic [3:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            commit,
  input  logic [PG_W-1:0] commit_page,
  output logic [PG_W-1:0] start_pg,
  output logic [PG_W-1:0] stop_pg,
  output logic [PG_W-1:0] bnry_pg,
  output logic [PG_W-1:0] cur_pg
);
  localparam logic [3:0] OFS_START = 4'h1;
  localparam logic [3:0] OFS_STOP  = 4'h2;
  localparam logic [3:0] OFS_BNRY  = 4'h3;
  localparam logic [3:0] OFS_CUR   = 4'h7;

  logic wr_p0, wr_cur;
  assign wr_p0  = cfg_we && !cfg_page;
  assign wr_cur = cfg_we && cfg_page && (cfg_addr == OFS_CUR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pg <= RST_START;
      stop_pg  <= RST_STOP;
      bnry_pg  <= RST_START;
    end else if (wr_p0) begin
      case (cfg_addr)
        OFS_START: start_pg <= cfg_wdata[PG_W-1:0];
        OFS_STOP:  stop_pg  <= cfg_wdata[PG_W-1:0];
        OFS_BNRY:  bnry_pg  <= cfg_wdata[PG_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_pg <= RST_START;
    else if (commit)  cur_pg <= commit_page;
    else if (wr_cur)  cur_pg <= cfg_wdata[PG_W-1:0];
  end

  // R7/R8: current page moves only on a commit or a host write
  a_r7_cur_moves_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !wr_cur) |=> $stable(cur_pg));
endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_good,
  input  logic              rx_crc_err,
  input  logic              rx_align_err,
  input  logic              rx_fifo_err,
  input  logic [PG_W-1:0]   start_pg,
  input  logic [PG_W-1:0]   stop_pg,
  input  logic [PG_W-1:0]   bnry_pg,
  input  logic [PG_W-1:0]   cur_pg,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              commit,
  output logic [PG_W-1:0]   commit_page,
  output logic              frame_done,
  output logic              ovw_irq
);
  localparam logic [OFF_W-1:0] OFF_LAST  = {OFF_W{1'b1}};
  localparam logic [OFF_W-1:0] OFF_FIRST = OFF_W'(HDR_BYTES);

  wr_state_e          st;
  logic [PG_W-1:0]    wr_pg, frm_pg, nxt_pg;
  logic [OFF_W-1:0]   wr_off;
  logic [LEN_W-1:0]   cnt, len_q;
  logic [7:0]         status_q;
  logic [1:0]         hdr_idx;

  // named events used by the assertions
  logic               accept, cross_hit, end_hit, ovf;
  logic [PG_W-1:0]    pg_now, pg_nx, end_pg;
  logic [OFF_W-1:0]   off_now, off_nx;
  logic [LEN_W-1:0]   cnt_now;

  always_comb begin
    pg_now    = (st == ST_IDLE) ? cur_pg : wr_pg;
    off_now   = (st == ST_IDLE) ? OFF_FIRST : wr_off;
    cnt_now   = (st == ST_IDLE) ? LEN_W'(HDR_BYTES) : cnt;
    off_nx    = off_now + 1'b1;
    pg_nx     = (off_now == OFF_LAST) ? ring_step(pg_now, start_pg, stop_pg) : pg_now;
    end_pg    = (off_nx == '0) ? pg_nx : ring_step(pg_nx, start_pg, stop_pg);
    accept    = rx_valid && ((st == ST_IDLE) || (st == ST_DATA));
    cross_hit = (off_now == OFF_LAST) && (pg_nx == bnry_pg);
    end_hit   = rx_last && (off_nx != '0) && (end_pg == bnry_pg);
    ovf       = accept && (cross_hit || end_hit);
  end

  assign commit      = (st == ST_HDR) && (hdr_idx == 2'd3);
  assign commit_page = nxt_pg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      wr_pg      <= '0;
      wr_off     <= '0;
      frm_pg     <= '0;
      nxt_pg     <= '0;
      cnt        <= '0;
      len_q      <= '0;
      status_q   <= '0;
      hdr_idx    <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      frame_done <= 1'b0;
      ovw_irq    <= 1'b0;
    end else begin
      ram_we     <= 1'b0;
      frame_done <= 1'b0;
      ovw_irq    <= 1'b0;
      case (st)
        ST_IDLE, ST_DATA: begin
          if (rx_valid) begin
            if (st == ST_IDLE) frm_pg <= cur_pg;
            wr_pg  <= pg_nx;
            wr_off <= off_nx;
            cnt    <= cnt_now + 1'b1;
            if (!cross_hit) begin
              ram_we    <= 1'b1;
              ram_addr  <= {pg_now, off_now};
              ram_wdata <= rx_data;
            end else begin
              // last byte of a page may still be written; the hit is the page after
              ram_we    <= 1'b1;
              ram_addr  <= {pg_now, off_now};
              ram_wdata <= rx_data;
            end
            if (ovf) begin
              ovw_irq <= 1'b1;
              st      <= rx_last ? ST_IDLE : ST_DROP;
            end else if (rx_last) begin
              st       <= ST_HDR;
              nxt_pg   <= end_pg;
              len_q    <= cnt_now + 1'b1;
              status_q <= pack_status(rx_good, rx_crc_err, rx_align_err, rx_fifo_err);
              hdr_idx  <= '0;
            end else begin
              st <= ST_DATA;
            end
          end
        end
        ST_DROP: begin
          if (rx_valid && rx_last) st <= ST_IDLE;
        end
        ST_HDR: begin
          ram_we    <= 1'b1;
          ram_addr  <= {frm_pg, {(OFF_W-2){1'b0}}, hdr_idx};
          ram_wdata <= hdr_byte(hdr_idx, status_q, nxt_pg, len_q);
          hdr_idx   <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3) begin
            st         <= ST_IDLE;
            frame_done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // input assumption: no byte offered while the header is being written (R5)
  a_r5_quiet_during_header: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> !rx_valid);
  // R5: every header cycle yields a write in the first four bytes of a page
  a_r5_header_at_page_base: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |=> (ram_we && (ram_addr[OFF_W-1:2] == '0)));
  // R4: all writes stay inside the programmed ring
  a_r4_write_inside_ring: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_addr[ADDR_W-1:OFF_W] >= start_pg) && (ram_addr[ADDR_W-1:OFF_W] < stop_pg)));
  // R8: an abandoned frame never reaches the header stage
  a_r8_drop_skips_header: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (st != ST_HDR));
  // R9: warning and completion are never raised together
  a_r9_warn_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovw_irq && frame_done));
  // R3: consecutive payload bytes land on consecutive addresses within a page
  a_r3_payload_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && accept && (wr_off != '0)) |=> (ram_addr[OFF_W-1:0] != '0));
endmodule

// File: rtl/rx_page_ring.sv
`timescale 1ns/1ps
module rx_page_ring
  import rx_ring_pkg::*;
#(
  parameter logic [7:0] RST_START = 8'h46,
  parameter logic [7:0] RST_STOP  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_page,
  input  logic [3:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_good,
  input  logic        rx_crc_err,
  input  logic        rx_align_err,
  input  logic        rx_fifo_err,
  output logic        ram_we,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  output logic [7:0]  cur_page,
  output logic        frame_done,
  output logic        ovw_irq
);
  logic [PG_W-1:0] start_pg, stop_pg, bnry_pg, cur_pg, commit_page;
  logic            commit;

  rx_ring_cfg #(.RST_START(RST_START), .RST_STOP(RST_STOP)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .commit(commit), .commit_page(commit_page),
    .start_pg(start_pg), .stop_pg(stop_pg), .bnry_pg(bnry_pg), .cur_pg(cur_pg)
  );

  rx_ring_writer u_wr (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_good(rx_good),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err), .rx_fifo_err(rx_fifo_err),
    .start_pg(start_pg), .stop_pg(stop_pg), .bnry_pg(bnry_pg), .cur_pg(cur_pg),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .commit(commit), .commit_page(commit_page),
    .frame_done(frame_done), .ovw_irq(ovw_irq)
  );

  assign cur_page = cur_pg;

  // R1: nothing is written in the cycle right after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ram_we && !ovw_irq && !frame_done));
endmodule

// File: tb/rx_page_ring_test.sv
`timescale 1ns/1ps
module rx_page_ring_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_page = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_good = 1'b0;
  logic        rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_fifo_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        ram_we, frame_done, ovw_irq;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, cur_page;

  always #5 clk = ~clk;

  rx_page_ring uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_good(rx_good), .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .rx_fifo_err(rx_fifo_err), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cur_page(cur_page), .frame_done(frame_done), .ovw_irq(ovw_irq)
  );

  int tests = 0, fails = 0;
  int n_ovw = 0, n_done = 0;
  logic [23:0] exp_q[$];
  string tag = "R3";
  logic [7:0] m_start = 8'h46, m_stop = 8'h80, m_bnry = 8'h46, m_cur = 8'h46;

  task automatic check(input string rq, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // monitor: every RAM write is compared with the oldest predicted write
  always @(negedge clk) begin
    logic [23:0] e;
    if (rst_n) begin
      if (ovw_irq) n_ovw++;
      if (frame_done) n_done++;
      if (ram_we) begin
        if (exp_q.size() == 0) begin
          check(tag, "unexpected write addr", int'(ram_addr), -1);
        end else begin
          e = exp_q.pop_front();
          check(tag, "write addr", int'(ram_addr), int'(e[23:8]));
          check(tag, "write data", int'(ram_wdata), int'(e[7:0]));
        end
      end
    end
  end

  function automatic logic [7:0] step(input logic [7:0] p);
    return (p + 8'd1 == m_stop) ? m_start : p + 8'd1;
  endfunction

  task automatic cfg_write(input logic pg, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = pg; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: predicts writes from the requirements, then streams the frame
  task automatic send_frame(input string rq, input int n, input logic [7:0] seed,
                            input logic good, input logic crc, input logic align,
                            input logic fifo, input logic expect_ovw);
    logic [7:0] pg, off, endp, st;
    logic       hit;
    int         len, ovw0, done0;
    pg = m_cur; off = 8'd4; hit = 1'b0;
    tag = rq;
    for (int i = 0; i < n && !hit; i++) begin
      exp_q.push_back({pg, off, seed + 8'(i)});
      if (off == 8'hFF) begin
        off = 8'h00; pg = step(pg);
        if (pg == m_bnry) hit = 1'b1;     // R8
      end else begin
        off = off + 8'd1;
      end
    end
    endp = (off == 8'h00) ? pg : step(pg);
    if (!hit && endp == m_bnry) hit = 1'b1; // R9
    len = n + 4;
    st  = {4'b0000, fifo, align, crc, good};
    if (!hit) begin
      exp_q.push_back({m_cur, 8'd0, st});
      exp_q.push_back({m_cur, 8'd1, endp});
      exp_q.push_back({m_cur, 8'd2, 8'(len)});
      exp_q.push_back({m_cur, 8'd3, 8'(len >> 8)});
      m_cur = endp;
    end
    ovw0 = n_ovw; done0 = n_done;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
      rx_good = good; rx_crc_err = crc; rx_align_err = align; rx_fifo_err = fifo;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (8) @(negedge clk);
    check(rq, "pending writes left", exp_q.size(), 0);
    check(rq, "cur_page", int'(cur_page), int'(m_cur));
    check(rq, "overwrite pulses", n_ovw - ovw0, expect_ovw ? 1 : 0);
    check(rq, "done pulses", n_done - done0, expect_ovw ? 0 : 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset cur_page", int'(cur_page), 'h46);
    check("R1", "reset ram_we", int'(ram_we), 0);
    check("R1", "reset ovw_irq", int'(ovw_irq), 0);

    send_frame("R3", 10, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // header R5, next 0x47
    send_frame("R6", 20, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // status 0x02
    send_frame("R5", 300, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // spans two pages
    send_frame("R7", 252, 8'hC0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // ends exactly at page end

    cfg_write(1'b0, 4'h7, 8'h70);                                 // R2: ignored
    @(negedge clk);
    check("R2", "page0 offset7 leaves cur", int'(cur_page), int'(m_cur));

    cfg_write(1'b0, 4'h1, 8'h10); m_start = 8'h10;
    cfg_write(1'b0, 4'h2, 8'h14); m_stop  = 8'h14;
    cfg_write(1'b0, 4'h3, 8'h11); m_bnry  = 8'h11;
    cfg_write(1'b1, 4'h7, 8'h12); m_cur   = 8'h12;
    @(negedge clk);
    check("R2", "page1 offset7 sets cur", int'(cur_page), 'h12);

    send_frame("R7", 100, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // next 0x13
    cfg_write(1'b0, 4'h3, 8'h12); m_bnry = 8'h12;
    send_frame("R4", 300, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // wraps 0x13 -> 0x10, next 0x11
    send_frame("R8", 400, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);  // runs into boundary 0x12
    send_frame("R9", 100, 8'h99, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);  // next page would be 0x12
    cfg_write(1'b0, 4'h3, 8'h10); m_bnry = 8'h10;
    send_frame("R7", 50, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // recovers, next 0x12
    send_frame("R6", 5, 8'hE0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);    // status 0x0C

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule